// File: doc/BRIEF.md
# Access-Time Timeout Monitor

This block turns the card timing fields a host has already read from a memory card into a data timeout measured in host clock cycles, then counts host clocks against that limit. The time field carries an exponent and a mantissa that together give an asynchronous access time. The block converts that time to clocks, rounding up, using the host clock period. It adds the clock-count field, which is given in hundreds of clocks. For a write it scales the sum by a power of two, and for a worst-case budget it multiplies the result by ten.

The host drives the fields and the selects, then pulses the start strobe when a read command or a block write is issued. The limit is captured on that edge. From then on the block raises a timeout flag if the limit is reached first, or a done flag if the data-arrived (or busy-released) strobe comes first. Both flags hold until the next start. A reserved mantissa code is reported on an error output.

Top module: `access_timeout_monitor`

## Requirements
- R1: The mantissa is taacField[6:3], with codes 1..15 meaning 1.0, 1.2, 1.3, 1.5, 2.0, 2.5, 3.0, 3.5, 4.0, 4.5, 5.0, 5.5, 6.0, 7.0, 8.0. The exponent is taacField[2:0], with code 0 meaning 1 ns and each higher code ten times longer, up to 10 ms for code 7. The access time is the mantissa times the exponent unit.
- R2: The access time is converted to clocks as ceil(time / clkPeriodNs). A period of 0 is treated as 1 ns.
- R3: nsacField adds nsacField*100 clocks to the converted time. This sum is the read limit.
- R4: When writeSel=1 the read limit is multiplied by 2**r2wField. When writeSel=0, r2wField has no effect.
- R5: When worstSel=1 the limit is multiplied by 10, after any write scaling.
- R6: limitClocks takes the value computed from the inputs sampled at the start edge. It is visible from that edge and holds until the next start.
- R7: codeError is 1 from a start edge on if the mantissa code sampled there was 0. A reserved code contributes zero time. Otherwise codeError is 0.
- R8: With limit L and no arrival, timedOut rises on the L-th rising edge after the start edge. A limit of 0 times out on the first edge.
- R9: An arrivePulse sampled on edge k after the start edge, with 1 <= k <= L, sets done and stops counting. On edge L, arrival wins over timeout. timedOut and done are never both 1.
- R10: Flags hold until the next start. An arrivePulse outside a run is ignored. A start clears both flags and restarts the count, even mid-run or together with an arrival.
- R11: After reset, limitClocks, timedOut, done and codeError are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| taacField | input | 8 | Access-time field (mantissa and exponent) |
| nsacField | input | 8 | Clock-count field, in units of 100 clocks |
| r2wField | input | 3 | Write factor exponent |
| clkPeriodNs | input | 16 | Host clock period in ns |
| startPulse | input | 1 | Starts a measured access |
| writeSel | input | 1 | 1 = write (program) budget, 0 = read |
| worstSel | input | 1 | 1 = tenfold worst-case budget |
| arrivePulse | input | 1 | Data arrived or busy released |
| limitClocks | output | 40 | Captured limit in clocks |
| timedOut | output | 1 | Limit reached before arrival |
| done | output | 1 | Arrival before limit |
| codeError | output | 1 | Reserved mantissa code seen at start |

## Verification
The counter reaching the limit and the arrival strobe can fall on the same edge. The bench provokes this by asserting arrivePulse exactly on the L-th edge after a start with a small limit. It judges the result by requiring done=1 and timedOut=0 afterwards. A second collision, start together with arrival, is provoked mid-run and judged by both flags reading 0 and a fresh timeout appearing L edges later.

// File: rtl/atm_pkg.sv
package atm_pkg;

  typedef struct packed {
    logic loadLimit;
    logic clearCount;
    logic incCount;
  } ctrlStrobes_t;

  // mantissa code -> value times ten; code 0 is reserved and yields 0
  function automatic logic [7:0] mantTimesTen(input logic [3:0] code);
    case (code)
      4'd1:    return 8'd10;
      4'd2:    return 8'd12;
      4'd3:    return 8'd13;
      4'd4:    return 8'd15;
      4'd5:    return 8'd20;
      4'd6:    return 8'd25;
      4'd7:    return 8'd30;
      4'd8:    return 8'd35;
      4'd9:    return 8'd40;
      4'd10:   return 8'd45;
      4'd11:   return 8'd50;
      4'd12:   return 8'd55;
      4'd13:   return 8'd60;
      4'd14:   return 8'd70;
      4'd15:   return 8'd80;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [31:0] powTen(input logic [2:0] e);
    logic [31:0] acc;
    acc = 32'd1;
    for (int i = 0; i < 7; i++) begin
      if (i < int'(e)) acc = acc * 32'd10;
    end
    return acc;
  endfunction

endpackage

// File: rtl/atm_datapath.sv
module atm_datapath
  import atm_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int LIMIT_W  = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          taacField,
  input  logic [7:0]          nsacField,
  input  logic [2:0]          r2wField,
  input  logic [PERIOD_W-1:0] clkPeriodNs,
  input  logic                writeSel,
  input  logic                worstSel,
  input  ctrlStrobes_t        strobes,
  output logic                atLimit,
  output logic [LIMIT_W-1:0]  limitClocks,
  output logic                codeError
);

  localparam int NSAC_UNIT = 100;
  localparam int WORST_MUL = 10;

  logic [LIMIT_W-1:0] timeTenthNs;
  logic [LIMIT_W-1:0] periodTenthNs;
  logic [LIMIT_W-1:0] timeClocks;
  logic [LIMIT_W-1:0] readLimit;
  logic [LIMIT_W-1:0] scaledLimit;
  logic [LIMIT_W-1:0] nextLimit;
  logic [LIMIT_W-1:0] limitReg;
  logic [LIMIT_W-1:0] countReg;
  logic               errReg;

  always_comb begin
    timeTenthNs   = LIMIT_W'(mantTimesTen(taacField[6:3])) * LIMIT_W'(powTen(taacField[2:0]));
    periodTenthNs = (clkPeriodNs == '0) ? LIMIT_W'(10)
                                        : LIMIT_W'(clkPeriodNs) * LIMIT_W'(10);
    timeClocks    = (timeTenthNs + periodTenthNs - LIMIT_W'(1)) / periodTenthNs;
    readLimit     = timeClocks + LIMIT_W'(nsacField) * LIMIT_W'(NSAC_UNIT);
    scaledLimit   = writeSel ? (readLimit << r2wField) : readLimit;
    nextLimit     = worstSel ? scaledLimit * LIMIT_W'(WORST_MUL) : scaledLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitReg <= '0;
      errReg   <= 1'b0;
    end else if (strobes.loadLimit) begin
      limitReg <= nextLimit;
      errReg   <= (taacField[6:3] == 4'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (strobes.clearCount) begin
      countReg <= '0;
    end else if (strobes.incCount) begin
      countReg <= countReg + LIMIT_W'(1);
    end
  end

  assign atLimit     = (countReg + LIMIT_W'(1)) >= limitReg;
  assign limitClocks = limitReg;
  assign codeError   = errReg;

endmodule

// File: rtl/atm_control.sv
module atm_control
  import atm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         arrivePulse,
  input  logic         atLimit,
  output ctrlStrobes_t strobes,
  output logic         timedOut,
  output logic         done
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  always_comb begin
    strobes = '0;
    if (startPulse) begin
      strobes.loadLimit  = 1'b1;
      strobes.clearCount = 1'b1;
    end else if (state == ST_RUN && !arrivePulse && !atLimit) begin
      strobes.incCount = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timedOut <= 1'b0;
      done     <= 1'b0;
    end else if (startPulse) begin
      state    <= ST_RUN;
      timedOut <= 1'b0;
      done     <= 1'b0;
    end else if (state == ST_RUN) begin
      if (arrivePulse) begin
        done  <= 1'b1;
        state <= ST_IDLE;
      end else if (atLimit) begin
        timedOut <= 1'b1;
        state    <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/access_timeout_monitor.sv
module access_timeout_monitor
  import atm_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int LIMIT_W  = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          taacField,
  input  logic [7:0]          nsacField,
  input  logic [2:0]          r2wField,
  input  logic [PERIOD_W-1:0] clkPeriodNs,
  input  logic                startPulse,
  input  logic                writeSel,
  input  logic                worstSel,
  input  logic                arrivePulse,
  output logic [LIMIT_W-1:0]  limitClocks,
  output logic                timedOut,
  output logic                done,
  output logic                codeError
);

  ctrlStrobes_t strobes;
  logic         atLimit;

  atm_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .arrivePulse (arrivePulse),
    .atLimit     (atLimit),
    .strobes     (strobes),
    .timedOut    (timedOut),
    .done        (done)
  );

  atm_datapath #(.PERIOD_W(PERIOD_W), .LIMIT_W(LIMIT_W)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .taacField   (taacField),
    .nsacField   (nsacField),
    .r2wField    (r2wField),
    .clkPeriodNs (clkPeriodNs),
    .writeSel    (writeSel),
    .worstSel    (worstSel),
    .strobes     (strobes),
    .atLimit     (atLimit),
    .limitClocks (limitClocks),
    .codeError   (codeError)
  );

endmodule

// File: rtl/atm_checker.sv
module atm_checker #(
  parameter int LIMIT_W = 40
) (
  input logic               clk,
  input logic               rstN,
  input logic [7:0]         taacField,
  input logic               startPulse,
  input logic               arrivePulse,
  input logic [LIMIT_W-1:0] limitClocks,
  input logic               timedOut,
  input logic               done,
  input logic               codeError
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(timedOut && done)); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!timedOut && !done)); // R10

  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> $stable(limitClocks)); // R6

  AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut && !startPulse) |=> timedOut); // R10

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> done); // R10

  AST_ERR_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (codeError == ($past(taacField[6:3]) == 4'd0))); // R7

  AST_IDLE_ARRIVAL: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut && arrivePulse && !startPulse) |=> !done); // R10

endmodule

bind access_timeout_monitor atm_checker #(.LIMIT_W(LIMIT_W)) i_atm_checker (
  .clk         (clk),
  .rstN        (rstN),
  .taacField   (taacField),
  .startPulse  (startPulse),
  .arrivePulse (arrivePulse),
  .limitClocks (limitClocks),
  .timedOut    (timedOut),
  .done        (done),
  .codeError   (codeError)
);

// File: tb/test_access_timeout_monitor.sv
module test_access_timeout_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  taacField = '0;
  logic [7:0]  nsacField = '0;
  logic [2:0]  r2wField = '0;
  logic [15:0] clkPeriodNs = 16'd20;
  logic        startPulse = 1'b0;
  logic        writeSel = 1'b0;
  logic        worstSel = 1'b0;
  logic        arrivePulse = 1'b0;
  logic [39:0] limitClocks;
  logic        timedOut;
  logic        done;
  logic        codeError;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  access_timeout_monitor i_access_timeout_monitor (
    .clk(clk), .rstN(rstN), .taacField(taacField), .nsacField(nsacField),
    .r2wField(r2wField), .clkPeriodNs(clkPeriodNs), .startPulse(startPulse),
    .writeSel(writeSel), .worstSel(worstSel), .arrivePulse(arrivePulse),
    .limitClocks(limitClocks), .timedOut(timedOut), .done(done),
    .codeError(codeError)
  );

  typedef struct packed {
    logic [7:0]  taac;
    logic [7:0]  nsac;
    logic [2:0]  r2w;
    logic [15:0] period;
    logic        wr;
    logic        worst;
    logic        err;
    logic [39:0] limit;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h16, 8'd0,   3'd0, 16'd20, 1'b0, 1'b0, 1'b0, 40'd60000},      // R1 R2 1.2 ms
    '{8'h16, 8'd0,   3'd4, 16'd20, 1'b1, 1'b0, 1'b0, 40'd960000},     // R4 x16
    '{8'h16, 8'd0,   3'd4, 16'd20, 1'b1, 1'b1, 1'b0, 40'd9600000},    // R5 x10
    '{8'h0A, 8'd0,   3'd0, 16'd30, 1'b0, 1'b0, 1'b0, 40'd4},          // R2 round up
    '{8'h0A, 8'd2,   3'd0, 16'd30, 1'b0, 1'b0, 1'b0, 40'd204},        // R3
    '{8'h0A, 8'd2,   3'd2, 16'd30, 1'b1, 1'b1, 1'b0, 40'd8160},       // R4 R5
    '{8'h7F, 8'd255, 3'd7, 16'd20, 1'b1, 1'b1, 1'b0, 40'd5152640000}, // R1 max
    '{8'h02, 8'd1,   3'd0, 16'd20, 1'b0, 1'b0, 1'b1, 40'd100},        // R7 reserved
    '{8'h0A, 8'd0,   3'd0, 16'd0,  1'b0, 1'b0, 1'b0, 40'd100},        // R2 period 0
    '{8'h0A, 8'd0,   3'd7, 16'd20, 1'b0, 1'b0, 1'b0, 40'd5},          // R4 read ignores r2w
    '{8'h13, 8'd0,   3'd0, 16'd7,  1'b0, 1'b0, 1'b0, 40'd172}         // R1 R2 1.2 us
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [7:0] t, input logic [7:0] n, input logic [2:0] r,
                       input logic [15:0] p, input logic w, input logic wc);
    taacField = t; nsacField = n; r2wField = r; clkPeriodNs = p;
    writeSel = w; worstSel = wc;
  endtask

  // start edge falls between the two negedges
  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    check("R11 limit", limitClocks, 0);
    check("R11 timedOut", timedOut, 0);
    check("R11 done", done, 0);
    check("R11 codeError", codeError, 0);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].taac, VECS[i].nsac, VECS[i].r2w, VECS[i].period, VECS[i].wr, VECS[i].worst);
      pulseStart();
      check($sformatf("R6 vector %0d limit", i), limitClocks, VECS[i].limit);
      check($sformatf("R7 vector %0d codeError", i), codeError, VECS[i].err);
    end

    // R8: limit 5 times out on the fifth edge
    setup(8'h0A, 8'd0, 3'd0, 16'd20, 1'b0, 1'b0);
    pulseStart();
    check("R10 start clears flags", {timedOut, done}, 0);
    waitEdges(4);
    check("R8 no timeout before limit", timedOut, 0);
    waitEdges(1);
    check("R8 timeout at limit", timedOut, 1);
    // R10: arrival while idle ignored, flag holds
    @(negedge clk) arrivePulse = 1'b1;
    @(negedge clk) arrivePulse = 1'b0;
    check("R10 idle arrival done", done, 0);
    check("R10 timeout holds", timedOut, 1);
    // R6: changing inputs without start leaves limit
    setup(8'h7F, 8'd9, 3'd1, 16'd20, 1'b1, 1'b1);
    waitEdges(2);
    check("R6 limit held", limitClocks, 5);

    // R9: arrival on edge 3 wins
    setup(8'h0A, 8'd0, 3'd0, 16'd20, 1'b0, 1'b0);
    pulseStart();
    waitEdges(2);
    arrivePulse = 1'b1;
    waitEdges(1);
    arrivePulse = 1'b0;
    check("R9 done early", done, 1);
    waitEdges(6);
    check("R9 no later timeout", timedOut, 0);
    check("R10 done holds", done, 1);

    // R9: arrival on the limit edge wins over timeout
    pulseStart();
    waitEdges(4);
    arrivePulse = 1'b1;
    waitEdges(1);
    arrivePulse = 1'b0;
    check("R9 collision done", done, 1);
    check("R9 collision timedOut", timedOut, 0);

    // R10: start together with arrival mid-run restarts the count
    pulseStart();
    waitEdges(2);
    startPulse = 1'b1; arrivePulse = 1'b1;
    waitEdges(1);
    startPulse = 1'b0; arrivePulse = 1'b0;
    check("R10 restart flags clear", {timedOut, done}, 0);
    waitEdges(4);
    check("R10 restart no early timeout", timedOut, 0);
    waitEdges(1);
    check("R10 restart timeout", timedOut, 1);

    // R8: limit 0 (reserved mantissa, no clock term) times out on first edge
    setup(8'h02, 8'd0, 3'd0, 16'd20, 1'b0, 1'b0);
    pulseStart();
    check("R8 zero limit value", limitClocks, 0);
    check("R7 zero limit error", codeError, 1);
    waitEdges(1);
    check("R8 zero limit timeout", timedOut, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule